// File: doc/BRIEF.md
# Panel Sync Timing Generator

This block drives the timing side of a parallel RGB panel. It produces a pixel-clock enable and a pixel-clock level, and from the enable it steps a pixel and line counter that form horizontal sync, vertical sync and data enable. All widths, porches and active sizes come in as configuration fields. Most fields hold the wanted length minus one. The vertical back porch holds the plain line count, and zero is allowed there.

A four-stage sequencer brings the panel up and down in a fixed order. The stages are the clock, the sync generation, the display signal and the backlight PWM gate. Software raises one request per stage and waits for that stage's status output before it raises the next request. It takes the panel down the same way: display first, then sync, then clock, then PWM. The sync and display stages change only at a frame boundary, so no frame is ever cut short. The display stage also waits a programmable number of whole frames after sync starts. There is no streaming data interface; all pins are plain levels.

Top module: `panel_timing_gen`

## Requirements
- R1: While the clock status is set and bypass is clear, pix_ce pulses once every div+2 source cycles. The first pulse comes in the (div+2)-th cycle after the clock status rises. With bypass set, pix_ce is high every cycle. With the clock status clear, pix_ce stays low.
- R2: In divider mode, pclk_o is high in the first floor((div+2)/2) cycles of each divider period, XOR pclk_pol. In bypass mode, pclk_o sits at the pclk_pol level.
- R3: A line is (hsw_m1+1)+(hbp_m1+1)+(ppl_m1+1)+(hfp_m1+1) pixel ticks long and starts with the sync pulse. hsync_o is at its active level for the first hsw_m1+1 ticks of each line. The active level is high when hs_pol is 0 and low when hs_pol is 1.
- R4: A frame is (vsw_m1+1)+vbp+(rpf_m1+1)+(vfp_m1+1) lines long, with vbp taken without offset. vsync_o is at its active level (high when vs_pol is 0) for the first vsw_m1+1 lines.
- R5: de_o is high only when the display status is set and the position is inside the active region. Horizontally that is the ticks from hsw+hbp up to, but not including, hsw+hbp+ppl. Vertically it is the lines from vsw+vbp up to, but not including, vsw+vbp+rows. The lengths here are the real ones.
- R6: The clock status follows want_clk one cycle later. It is held set while the sync status is set, and it clears in the cycle after sync clears.
- R7: The sync status rises one cycle after want_sync, provided want_clk is high and the clock status is already set. Otherwise the request is ignored.
- R8: The sync status clears only at the end of a frame, and only once want_sync is low and the display status is clear. While sync is clear, the counters sit at the first pixel of the first sync line.
- R9: The display status rises only at a frame end, with want_disp and want_sync high. The frames completed since sync rose must be at least max(guard,1). The display status falls at the first frame end after want_disp goes low.
- R10: The PWM status rises one cycle after want_pwm if the display status is set, and is ignored otherwise. It falls one cycle after want_pwm goes low, whatever the other stages are doing.
- R11: With the sync status clear, hsync_o and vsync_o rest at their inactive levels and de_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | source clock |
| rst_n | input | 1 | active-low asynchronous reset |
| div | input | DIV_W | pixel divider field, period is div+2 |
| bypass | input | 1 | pixel enable every source cycle |
| pclk_pol | input | 1 | invert pixel clock level |
| hs_pol | input | 1 | hsync active low when 1 |
| vs_pol | input | 1 | vsync active low when 1 |
| hsw_m1 | input | HW | horizontal sync width minus one |
| hbp_m1 | input | HW | horizontal back porch minus one |
| ppl_m1 | input | HW | active pixels per line minus one |
| hfp_m1 | input | HW | horizontal front porch minus one |
| vsw_m1 | input | VW | vertical sync width minus one |
| vbp | input | VW | vertical back porch, no offset |
| rpf_m1 | input | VW | active rows minus one |
| vfp_m1 | input | VW | vertical front porch minus one |
| guard | input | GW | frames to wait before display |
| want_clk | input | 1 | clock stage request |
| want_sync | input | 1 | sync stage request |
| want_disp | input | 1 | display stage request |
| want_pwm | input | 1 | PWM stage request |
| pix_ce | output | 1 | pixel clock enable |
| pclk_o | output | 1 | pixel clock level |
| hsync_o | output | 1 | horizontal sync |
| vsync_o | output | 1 | vertical sync |
| de_o | output | 1 | data enable |
| st_clk | output | 1 | clock stage status |
| st_sync | output | 1 | sync stage status |
| st_disp | output | 1 | display stage status |
| st_pwm | output | 1 | PWM stage status |

## Verification
The hardest case to reach is a stage change at a frame boundary while the divider runs slower than the source clock. The request has to be dropped at some arbitrary point mid-frame, and the status has to follow exactly at the wrap. To get there, the stimulus sweeps divider settings, bypass, polarities, guard counts and two tiny timings, one of them with a zero vertical back porch. Each frame is only tens of pixels long, so every session drives full bring-up, several frames and an ordered shutdown. The requests are released at offsets that move with each configuration. The bench counts pixel ticks since sync rose and checks every sync, enable and status transition against the frame length.

// File: rtl/panel_timing_pkg.sv
package panel_timing_pkg;
  typedef struct packed {
    logic clk;
    logic sync;
    logic disp;
    logic pwm;
  } stage_vec_t;
endpackage

// File: rtl/pixclk_div.sv
module pixclk_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             bypass,
  input  logic [DIV_W-1:0] div,
  input  logic             pol,
  output logic             ce,
  output logic             lvl
);
  localparam int CW = DIV_W + 2;

  logic [CW-1:0] cnt;
  logic [CW-1:0] last;
  logic [CW-1:0] half;

  assign last = CW'(div) + CW'(1);
  assign half = (CW'(div) + CW'(2)) >> 1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!run || bypass || cnt == last) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + CW'(1);
    end
  end

  assign ce  = run & (bypass | (cnt == last));
  assign lvl = bypass ? pol : ((cnt < half) ^ pol);
endmodule

// File: rtl/sync_counters.sv
module sync_counters #(
  parameter int HW = 11,
  parameter int VW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          ce,
  input  logic [HW-1:0] hsw_m1,
  input  logic [HW-1:0] hbp_m1,
  input  logic [HW-1:0] ppl_m1,
  input  logic [HW-1:0] hfp_m1,
  input  logic [VW-1:0] vsw_m1,
  input  logic [VW-1:0] vbp,
  input  logic [VW-1:0] rpf_m1,
  input  logic [VW-1:0] vfp_m1,
  output logic          hs_act,
  output logic          vs_act,
  output logic          in_active,
  output logic          frame_end
);
  localparam int HC = HW + 2;
  localparam int VC = VW + 2;

  logic [HC-1:0] h_cnt, hs_len, h_a0, h_a1, h_last;
  logic [VC-1:0] v_cnt, vs_len, v_a0, v_a1, v_last;
  logic          line_end;

  assign hs_len = HC'(hsw_m1) + HC'(1);
  assign h_a0   = hs_len + HC'(hbp_m1) + HC'(1);
  assign h_a1   = h_a0 + HC'(ppl_m1) + HC'(1);
  assign h_last = h_a1 + HC'(hfp_m1);

  assign vs_len = VC'(vsw_m1) + VC'(1);
  assign v_a0   = vs_len + VC'(vbp);
  assign v_a1   = v_a0 + VC'(rpf_m1) + VC'(1);
  assign v_last = v_a1 + VC'(vfp_m1);

  assign line_end = (h_cnt == h_last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_cnt <= '0;
      v_cnt <= '0;
    end else if (!run) begin
      h_cnt <= '0;
      v_cnt <= '0;
    end else if (ce) begin
      if (line_end) begin
        h_cnt <= '0;
        v_cnt <= (v_cnt == v_last) ? '0 : v_cnt + VC'(1);
      end else begin
        h_cnt <= h_cnt + HC'(1);
      end
    end
  end

  assign frame_end = run & ce & line_end & (v_cnt == v_last);
  assign hs_act    = run & (h_cnt < hs_len);
  assign vs_act    = run & (v_cnt < vs_len);
  assign in_active = run & (h_cnt >= h_a0) & (h_cnt < h_a1)
                         & (v_cnt >= v_a0) & (v_cnt < v_a1);
endmodule

// File: rtl/power_seq.sv
module power_seq
  import panel_timing_pkg::*;
#(
  parameter int GW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          want_clk,
  input  logic          want_sync,
  input  logic          want_disp,
  input  logic          want_pwm,
  input  logic          frame_end,
  input  logic [GW-1:0] guard,
  output stage_vec_t    st
);
  logic [GW-1:0] frames;
  logic          guard_met;

  assign guard_met = (({1'b0, frames} + (GW+1)'(1)) >= {1'b0, guard});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= '0;
      frames <= '0;
    end else begin
      st.clk <= want_clk | st.sync;

      if (!st.sync) begin
        st.sync <= want_sync & want_clk & st.clk;
      end else if (frame_end && !want_sync && !st.disp) begin
        st.sync <= 1'b0;
      end

      if (!st.sync) begin
        frames <= '0;
      end else if (frame_end && frames != '1) begin
        frames <= frames + GW'(1);
      end

      if (!st.disp) begin
        st.disp <= frame_end & want_disp & want_sync & st.sync & guard_met;
      end else if (frame_end && !want_disp) begin
        st.disp <= 1'b0;
      end

      st.pwm <= st.pwm ? want_pwm : (want_pwm & st.disp);
    end
  end
endmodule

// File: rtl/panel_timing_gen.sv
module panel_timing_gen
  import panel_timing_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int HW    = 11,
  parameter int VW    = 11,
  parameter int GW    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  input  logic             bypass,
  input  logic             pclk_pol,
  input  logic             hs_pol,
  input  logic             vs_pol,
  input  logic [HW-1:0]    hsw_m1,
  input  logic [HW-1:0]    hbp_m1,
  input  logic [HW-1:0]    ppl_m1,
  input  logic [HW-1:0]    hfp_m1,
  input  logic [VW-1:0]    vsw_m1,
  input  logic [VW-1:0]    vbp,
  input  logic [VW-1:0]    rpf_m1,
  input  logic [VW-1:0]    vfp_m1,
  input  logic [GW-1:0]    guard,
  input  logic             want_clk,
  input  logic             want_sync,
  input  logic             want_disp,
  input  logic             want_pwm,
  output logic             pix_ce,
  output logic             pclk_o,
  output logic             hsync_o,
  output logic             vsync_o,
  output logic             de_o,
  output logic             st_clk,
  output logic             st_sync,
  output logic             st_disp,
  output logic             st_pwm
);
  stage_vec_t st;
  logic       hs_act, vs_act, in_active, frame_end;

  pixclk_div #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .run(st.clk), .bypass(bypass),
    .div(div), .pol(pclk_pol), .ce(pix_ce), .lvl(pclk_o)
  );

  sync_counters #(.HW(HW), .VW(VW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(st.sync), .ce(pix_ce),
    .hsw_m1(hsw_m1), .hbp_m1(hbp_m1), .ppl_m1(ppl_m1), .hfp_m1(hfp_m1),
    .vsw_m1(vsw_m1), .vbp(vbp), .rpf_m1(rpf_m1), .vfp_m1(vfp_m1),
    .hs_act(hs_act), .vs_act(vs_act), .in_active(in_active),
    .frame_end(frame_end)
  );

  power_seq #(.GW(GW)) u_seq (
    .clk(clk), .rst_n(rst_n), .want_clk(want_clk), .want_sync(want_sync),
    .want_disp(want_disp), .want_pwm(want_pwm), .frame_end(frame_end),
    .guard(guard), .st(st)
  );

  assign hsync_o = hs_act ^ hs_pol;
  assign vsync_o = vs_act ^ vs_pol;
  assign de_o    = in_active & st.disp;
  assign st_clk  = st.clk;
  assign st_sync = st.sync;
  assign st_disp = st.disp;
  assign st_pwm  = st.pwm;
endmodule

// File: rtl/panel_timing_chk.sv
module panel_timing_chk (
  input logic clk,
  input logic rst_n,
  input logic pix_ce,
  input logic hsync_o,
  input logic vsync_o,
  input logic hs_pol,
  input logic vs_pol,
  input logic de_o,
  input logic st_clk,
  input logic st_sync,
  input logic st_disp,
  input logic st_pwm,
  input logic want_pwm,
  input logic frame_end
);
  a_r1_no_ce_without_clk: assert property (@(posedge clk) disable iff (!rst_n)
    pix_ce |-> st_clk);
  a_r6_clk_held_by_sync: assert property (@(posedge clk) disable iff (!rst_n)
    st_sync |-> st_clk);
  a_r8_sync_drop_at_frame_end: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(st_sync) |-> $past(frame_end));
  a_r9_disp_needs_sync: assert property (@(posedge clk) disable iff (!rst_n)
    st_disp |-> st_sync);
  a_r9_disp_rise_at_frame_end: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_disp) |-> $past(frame_end));
  a_r5_de_needs_disp: assert property (@(posedge clk) disable iff (!rst_n)
    de_o |-> st_disp);
  a_r10_pwm_rise_after_disp: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_pwm) |-> $past(st_disp) && $past(want_pwm));
  a_r11_idle_levels: assert property (@(posedge clk) disable iff (!rst_n)
    !st_sync |-> (hsync_o == hs_pol) && (vsync_o == vs_pol) && !de_o);
endmodule

bind panel_timing_gen panel_timing_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pix_ce(pix_ce), .hsync_o(hsync_o),
  .vsync_o(vsync_o), .hs_pol(hs_pol), .vs_pol(vs_pol), .de_o(de_o),
  .st_clk(st_clk), .st_sync(st_sync), .st_disp(st_disp), .st_pwm(st_pwm),
  .want_pwm(want_pwm), .frame_end(frame_end)
);

// File: tb/test_panel_timing_gen.sv
module test_panel_timing_gen;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0]  div = '0;
  logic bypass = 1'b0, pclk_pol = 1'b0, hs_pol = 1'b0, vs_pol = 1'b0;
  logic [10:0] hsw_m1 = '0, hbp_m1 = '0, ppl_m1 = '0, hfp_m1 = '0;
  logic [10:0] vsw_m1 = '0, vbp = '0, rpf_m1 = '0, vfp_m1 = '0;
  logic [3:0]  guard = 4'd1;
  logic want_clk = 0, want_sync = 0, want_disp = 0, want_pwm = 0;
  logic pix_ce, pclk_o, hsync_o, vsync_o, de_o, st_clk, st_sync, st_disp, st_pwm;

  int n_cmp = 0, n_bad = 0;
  int p = 0, k = 0;
  bit prev_sync = 0, prev_disp = 0;

  always #2 clk = ~clk;

  panel_timing_gen i_panel_timing_gen (
    .clk(clk), .rst_n(rst_n), .div(div), .bypass(bypass), .pclk_pol(pclk_pol),
    .hs_pol(hs_pol), .vs_pol(vs_pol), .hsw_m1(hsw_m1), .hbp_m1(hbp_m1),
    .ppl_m1(ppl_m1), .hfp_m1(hfp_m1), .vsw_m1(vsw_m1), .vbp(vbp),
    .rpf_m1(rpf_m1), .vfp_m1(vfp_m1), .guard(guard), .want_clk(want_clk),
    .want_sync(want_sync), .want_disp(want_disp), .want_pwm(want_pwm),
    .pix_ce(pix_ce), .pclk_o(pclk_o), .hsync_o(hsync_o), .vsync_o(vsync_o),
    .de_o(de_o), .st_clk(st_clk), .st_sync(st_sync), .st_disp(st_disp),
    .st_pwm(st_pwm)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int hlen();
    return int'(hsw_m1) + int'(hbp_m1) + int'(ppl_m1) + int'(hfp_m1) + 4;
  endfunction
  function automatic int vlen();
    return int'(vsw_m1) + int'(vbp) + int'(rpf_m1) + int'(vfp_m1) + 3;
  endfunction

  // Continuous monitor: predicted waveforms from pixel tick count
  always @(negedge clk) begin
    if (rst_n) begin
      if (st_clk) begin
        int per, half;
        bit e_ce, e_lvl;
        per  = int'(div) + 2;
        half = per / 2;
        e_ce  = bypass ? 1'b1 : (p == per - 1);
        e_lvl = bypass ? pclk_pol : ((p < half) ^ pclk_pol);
        chk(pix_ce == e_ce, "R1 pix_ce", pix_ce, e_ce);
        chk(pclk_o == e_lvl, "R2 pclk_o", pclk_o, e_lvl);
        p = (bypass || p == per - 1) ? 0 : p + 1;
      end else begin
        chk(pix_ce == 1'b0, "R1 ce idle", pix_ce, 0);
        p = 0;
      end

      if (st_sync) begin
        int hh, vv, h, v, ha0, ha1, va0, va1;
        bit e_hs, e_vs, e_de;
        hh = hlen(); vv = vlen();
        h = k % hh; v = (k / hh) % vv;
        ha0 = int'(hsw_m1) + int'(hbp_m1) + 2; ha1 = ha0 + int'(ppl_m1) + 1;
        va0 = int'(vsw_m1) + 1 + int'(vbp);     va1 = va0 + int'(rpf_m1) + 1;
        e_hs = (h <= int'(hsw_m1)) ^ hs_pol;
        e_vs = (v <= int'(vsw_m1)) ^ vs_pol;
        e_de = st_disp && h >= ha0 && h < ha1 && v >= va0 && v < va1;
        chk(hsync_o == e_hs, "R3 hsync", hsync_o, e_hs);
        chk(vsync_o == e_vs, "R4 vsync", vsync_o, e_vs);
        chk(de_o == e_de, "R5 de", de_o, e_de);
        if (st_disp && !prev_disp) begin
          int g;
          g = (guard == 0) ? 1 : int'(guard);
          chk(k == g * hh * vv, "R9 disp rise frame", k, g * hh * vv);
        end
        if (!st_disp && prev_disp)
          chk(k % (hh * vv) == 0, "R9 disp fall boundary", k % (hh * vv), 0);
        if (pix_ce) k++;
      end else begin
        if (prev_sync)
          chk(k % (hlen() * vlen()) == 0, "R8 sync fall boundary", k % (hlen() * vlen()), 0);
        chk(hsync_o == hs_pol, "R11 hsync idle", hsync_o, hs_pol);
        chk(vsync_o == vs_pol, "R11 vsync idle", vsync_o, vs_pol);
        chk(de_o == 1'b0, "R11 de idle", de_o, 0);
        k = 0;
      end
      prev_sync = st_sync;
      prev_disp = st_disp;
    end
  end

  task automatic wait_for(input int which, input bit val, input string tag);
    int n = 0;
    bit cur;
    do begin
      @(negedge clk);
      n++;
      case (which)
        0: cur = st_sync;
        1: cur = st_disp;
        default: cur = st_clk;
      endcase
    end while (cur != val && n < 5000);
    chk(cur == val, tag, cur, val);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(st_clk == 0 && st_sync == 0 && st_disp == 0 && st_pwm == 0, "R6 reset status", st_sync, 0);
    rst_n = 1'b1;
    // R7: sync request without clock is ignored; R9/R10 requests without stages ignored
    want_sync = 1; want_disp = 1; want_pwm = 1;
    repeat (6) @(negedge clk);
    chk(st_sync == 0, "R7 sync ignored without clk", st_sync, 0);
    chk(st_disp == 0, "R9 disp ignored", st_disp, 0);
    chk(st_pwm == 0, "R10 pwm ignored", st_pwm, 0);
    want_sync = 0; want_disp = 0; want_pwm = 0;

    for (int c = 0; c < 8; c++) begin
      div = 8'(c % 3); bypass = (c >= 6);
      hs_pol = c[0]; vs_pol = c[1]; pclk_pol = c[2];
      guard = 4'((c % 3 == 2) ? 0 : 1 + c % 2);
      if (c % 2 == 0) begin
        hsw_m1 = 1; hbp_m1 = 0; ppl_m1 = 2; hfp_m1 = 0;
        vsw_m1 = 0; vbp = 0; rpf_m1 = 1; vfp_m1 = 0;
      end else begin
        hsw_m1 = 0; hbp_m1 = 1; ppl_m1 = 3; hfp_m1 = 1;
        vsw_m1 = 1; vbp = 2; rpf_m1 = 2; vfp_m1 = 1;
      end
      want_clk = 1;
      @(negedge clk);
      chk(st_clk == 1, "R6 clk rises next cycle", st_clk, 1);
      want_sync = 1; want_disp = 1;
      @(negedge clk);
      chk(st_sync == 1, "R7 sync rises next cycle", st_sync, 1);
      want_pwm = 1;
      wait_for(1, 1, "R9 disp up");
      chk(st_pwm == 0, "R10 pwm waits for disp", st_pwm, 0);
      @(negedge clk);
      chk(st_pwm == 1, "R10 pwm up", st_pwm, 1);
      // let a frame or two run, then release requests mid-frame
      repeat (40 + 7 * c) @(negedge clk);
      want_disp = 0; want_sync = 0; want_clk = 0;
      repeat (3) @(negedge clk);
      chk(st_clk == 1, "R6 clk held while sync", st_clk, 1);
      wait_for(1, 0, "R9 disp down");
      chk(st_sync == 1, "R8 sync waits for disp", st_sync, 1);
      wait_for(0, 0, "R8 sync down");
      chk(st_clk == 1, "R6 clk one more cycle", st_clk, 1);
      @(negedge clk);
      chk(st_clk == 0, "R6 clk down after sync", st_clk, 0);
      chk(st_pwm == 1, "R10 pwm still up", st_pwm, 1);
      want_pwm = 0;
      @(negedge clk);
      chk(st_pwm == 0, "R10 pwm down", st_pwm, 0);
      repeat (3) @(negedge clk);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule